// File: doc/BRIEF.md
# Row Routing Fabric with Lookup-Table Outputs

This block is one routing row placed between a group of logic blocks and four 8-bit global buses: an even input bus, an odd input bus, an even output bus and an odd output bus. The even buses serve the even-numbered ports and the odd buses serve the odd-numbered ports. On the input side, four row-input nets feed the logic blocks. A 4-to-1 selector drives each of these nets. The candidate sets of the four selectors do not overlap, and together they reach every one of the sixteen global input lines.

On the output side, the logic blocks drive four raw row nets. Each output stage combines two neighbouring raw nets in a 2-input lookup table. A 4-bit function code chooses any of the sixteen Boolean functions for that table. Each table result can reach four global output lines, and each of those lines has its own enable bit.

A small register file holds every select, function code and enable. Software writes it through a single-cycle write port. A write takes effect at the clock edge that accepts it, and it can happen at any time during operation. All routing from the register contents and bus inputs to the outputs is combinational.

Top module: `rowroute_top`

## Requirements
- R1: After reset every select field, function code and enable bit is 0. As a result, row-input net i carries global line i and both global output buses read 0 for every input pattern.
- R2: Global line numbering is as follows: line j is even-bus bit j for j below 8, and odd-bus bit j-8 for j from 8 to 15. Row-input net i with select value s carries line 4*s+i.
- R3: Every global input line reaches exactly one row-input net under exactly one select value.
- R4: Output table x takes A from raw row net x and B from raw row net (x+1) mod 4. Its result equals bit {~A,~B} of its 4-bit code. Bit 0 applies when A=1 and B=1, bit 1 when A=1 and B=0, bit 2 when A=0 and B=1, and bit 3 when A=0 and B=0.
- R5: The following named codes behave as stated: 0000 gives FALSE, 1111 gives TRUE, 0011 passes A, 0101 passes B, 0110 gives XOR, 0111 gives OR, 1000 gives NOR, 1001 gives XNOR and 1110 gives NAND.
- R6: Global output line j is driven only by table j mod 4, gated by enable bit j. A line whose enable is clear reads 0. If several drivers were enabled on one line, their values would be ORed.
- R7: A configuration write changes the outputs only after the rising clock edge that samples it. Before that edge, the outputs still reflect the old contents.
- R8: Write address 0 holds the selects, with net i at bits [2i+1:2i]. Address 1 holds the codes, with table x at bits [4x+3:4x]. Address 2 holds the enables, with line j at bit j.
- R9: A write to address 3 changes no configuration and has no effect on any output.
- R10: While no write occurs and the bus and raw-net inputs hold steady, all outputs stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register address |
| cfgWrData | input | 16 | Configuration write data |
| gInEven | input | 8 | Even global input bus |
| gInOdd | input | 8 | Odd global input bus |
| rowDrv | input | 4 | Raw row nets driven by the logic blocks |
| rowIn | output | 4 | Row-input nets to the logic blocks |
| gOutEven | output | 8 | Even global output bus |
| gOutOdd | output | 8 | Odd global output bus |

## Verification
The bench sweeps every select value against one-hot input patterns on all sixteen lines. It also counts how often each line arrives anywhere, so a selector that overlaps another group, or that wraps between the even and odd buses, shows up as a line that is reached twice or never. All sixteen codes are crossed with all sixteen raw-net patterns. This catches a design with an inverted table index or a wrong A/B pairing, because such a design would return the mirror function (for example "A AND NOT B" where "NOT A AND B" is expected). One-hot enable sweeps expose fan-out wired to the wrong table or line. Finally, the bench probes the outputs between the moment a write is presented and the clock edge that accepts it, and it writes to the spare address, so a design that passes writes straight through or decodes the spare address as a live register is caught.

// File: rtl/rowroute_pkg.sv
package rowroute_pkg;

  localparam int unsigned CFG_AW   = 2;
  localparam int unsigned CODE_W   = 4;

  localparam logic [CFG_AW-1:0] ADDR_SEL  = 2'd0;
  localparam logic [CFG_AW-1:0] ADDR_CODE = 2'd1;
  localparam logic [CFG_AW-1:0] ADDR_EN   = 2'd2;

  typedef struct packed {
    logic ldSel;
    logic ldCode;
    logic ldEn;
  } cfgStrobe_t;

endpackage

// File: rtl/rowroute_ctrl.sv
module rowroute_ctrl
  import rowroute_pkg::*;
(
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  output cfgStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    if (cfgWrEn) begin
      unique case (cfgAddr)
        ADDR_SEL:  strobe.ldSel  = 1'b1;
        ADDR_CODE: strobe.ldCode = 1'b1;
        ADDR_EN:   strobe.ldEn   = 1'b1;
        default:   strobe        = '0;
      endcase
    end
  end

endmodule

// File: rtl/rowroute_datapath.sv
module rowroute_datapath
  import rowroute_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned NETS   = 4,
  parameter int unsigned CFG_DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [CFG_DW-1:0] wrData,
  input  logic [BUS_W-1:0]  gInEven,
  input  logic [BUS_W-1:0]  gInOdd,
  input  logic [NETS-1:0]   rowDrv,
  output logic [NETS-1:0]   rowIn,
  output logic [BUS_W-1:0]  gOutEven,
  output logic [BUS_W-1:0]  gOutOdd
);

  localparam int unsigned LINES     = 2 * BUS_W;
  localparam int unsigned CANDS     = LINES / NETS;
  localparam int unsigned SEL_W     = (CANDS > 1) ? $clog2(CANDS) : 1;
  localparam int unsigned SELREG_W  = NETS * SEL_W;
  localparam int unsigned CODEREG_W = NETS * CODE_W;

  logic [SELREG_W-1:0]  selReg;
  logic [CODEREG_W-1:0] codeReg;
  logic [LINES-1:0]     enReg;

  // configuration register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= '0;
      codeReg <= '0;
      enReg   <= '0;
    end else begin
      if (strobe.ldSel)  selReg  <= wrData[SELREG_W-1:0];
      if (strobe.ldCode) codeReg <= wrData[CODEREG_W-1:0];
      if (strobe.ldEn)   enReg   <= wrData[LINES-1:0];
    end
  end

  // flat view of the global input lines: even bus low, odd bus high
  logic [LINES-1:0] gInAll;
  assign gInAll = {gInOdd, gInEven};

  // input side: disjoint candidate groups, net i sees lines k*NETS+i
  for (genvar i = 0; i < NETS; i++) begin : g_inSel
    logic [CANDS-1:0] cand;
    logic [SEL_W-1:0] sel;
    for (genvar k = 0; k < CANDS; k++) begin : g_cand
      assign cand[k] = gInAll[k*NETS + i];
    end
    assign sel      = selReg[i*SEL_W +: SEL_W];
    assign rowIn[i] = cand[sel];
  end

  // output side: neighbouring raw nets into a 2-input table
  logic [NETS-1:0] lutOut;
  for (genvar x = 0; x < NETS; x++) begin : g_lut
    logic [CODE_W-1:0] code;
    logic              opA;
    logic              opB;
    logic [1:0]        idx;
    assign code      = codeReg[x*CODE_W +: CODE_W];
    assign opA       = rowDrv[x];
    assign opB       = rowDrv[(x+1) % NETS];
    assign idx       = {~opA, ~opB};
    assign lutOut[x] = code[idx];
  end

  // fan-out: each line ORs its enabled drivers, empty line reads 0
  logic [LINES-1:0] gOutAll;
  for (genvar j = 0; j < LINES; j++) begin : g_fan
    logic [NETS-1:0] drv;
    for (genvar x = 0; x < NETS; x++) begin : g_drv
      if (x == (j % NETS)) begin : g_on
        assign drv[x] = enReg[j] & lutOut[x];
      end else begin : g_off
        assign drv[x] = 1'b0;
      end
    end
    assign gOutAll[j] = |drv;
  end

  assign gOutEven = gOutAll[BUS_W-1:0];
  assign gOutOdd  = gOutAll[LINES-1:BUS_W];

endmodule

// File: rtl/rowroute_top.sv
module rowroute_top
  import rowroute_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned NETS   = 4,
  parameter int unsigned CFG_DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [CFG_DW-1:0] cfgWrData,
  input  logic [BUS_W-1:0]  gInEven,
  input  logic [BUS_W-1:0]  gInOdd,
  input  logic [NETS-1:0]   rowDrv,
  output logic [NETS-1:0]   rowIn,
  output logic [BUS_W-1:0]  gOutEven,
  output logic [BUS_W-1:0]  gOutOdd
);

  cfgStrobe_t strobe;

  rowroute_ctrl u_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .strobe  (strobe)
  );

  rowroute_datapath #(
    .BUS_W  (BUS_W),
    .NETS   (NETS),
    .CFG_DW (CFG_DW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (cfgWrData),
    .gInEven  (gInEven),
    .gInOdd   (gInOdd),
    .rowDrv   (rowDrv),
    .rowIn    (rowIn),
    .gOutEven (gOutEven),
    .gOutOdd  (gOutOdd)
  );

endmodule

// File: rtl/rowroute_checker.sv
module rowroute_checker
  import rowroute_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned NETS   = 4,
  parameter int unsigned CFG_DW = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [1:0]        cfgAddr,
  input logic [CFG_DW-1:0] cfgWrData,
  input logic [BUS_W-1:0]  gInEven,
  input logic [BUS_W-1:0]  gInOdd,
  input logic [NETS-1:0]   rowDrv,
  input logic [NETS-1:0]   rowIn,
  input logic [BUS_W-1:0]  gOutEven,
  input logic [BUS_W-1:0]  gOutOdd,
  input cfgStrobe_t        strobe
);

  localparam int unsigned LINES = 2 * BUS_W;

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1: outputs are zero at the first active edge after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (gOutEven == '0 && gOutOdd == '0));

  // R6: clearing all enables silences both output buses
  assert_enables_cleared_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == ADDR_EN && cfgWrData[LINES-1:0] == '0)
      |=> (gOutEven == '0 && gOutOdd == '0));

  // R9: spare address loads nothing
  assert_spare_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == 2'd3) |-> (strobe == '0));

  // R8: at most one register loads per write
  assert_one_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ldSel, strobe.ldCode, strobe.ldEn}));

  // R10: quiet inputs and no write keep outputs constant
  assert_quiet_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(cfgWrEn) && $stable(gInEven) && $stable(gInOdd) && $stable(rowDrv))
      |-> ($stable(rowIn) && $stable(gOutEven) && $stable(gOutOdd)));

endmodule

bind rowroute_top rowroute_checker #(
  .BUS_W  (BUS_W),
  .NETS   (NETS),
  .CFG_DW (CFG_DW)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgAddr   (cfgAddr),
  .cfgWrData (cfgWrData),
  .gInEven   (gInEven),
  .gInOdd    (gInOdd),
  .rowDrv    (rowDrv),
  .rowIn     (rowIn),
  .gOutEven  (gOutEven),
  .gOutOdd   (gOutOdd),
  .strobe    (strobe)
);

// File: tb/sim_rowroute_top.sv
`timescale 1ns/1ps
module sim_rowroute_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic [7:0]  gInEven = '0;
  logic [7:0]  gInOdd = '0;
  logic [3:0]  rowDrv = '0;
  logic [3:0]  rowIn;
  logic [7:0]  gOutEven;
  logic [7:0]  gOutOdd;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int hitCount [16];

  always #2.5 clk = ~clk;

  rowroute_top u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .gInEven(gInEven), .gInOdd(gInOdd),
    .rowDrv(rowDrv), .rowIn(rowIn), .gOutEven(gOutEven), .gOutOdd(gOutOdd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(posedge clk);
    #1 cfgWrEn = 1'b0;
  endtask

  task automatic driveLine(input int j);
    logic [15:0] all;
    all = 16'h1 << j;
    gInEven = all[7:0];
    gInOdd  = all[15:8];
    #1;
  endtask

  function automatic logic lutExp(input logic [3:0] code, input logic a, input logic b);
    int idx;
    idx = (a ? 0 : 2) + (b ? 0 : 1);
    return code[idx];
  endfunction

  function automatic logic [15:0] gOutExp(input logic [15:0] codes, input logic [15:0] en,
                                          input logic [3:0] drv);
    logic [15:0] r;
    for (int j = 0; j < 16; j++) begin
      int x;
      x = j % 4;
      r[j] = en[j] & lutExp(codes[x*4 +: 4], drv[x], drv[(x+1) % 4]);
    end
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int j = 0; j < 16; j++) begin
      logic [3:0] e;
      driveLine(j);
      e = (j < 4) ? (4'h1 << j) : 4'h0;
      check("R1 rowIn after reset", {28'h0, rowIn}, {28'h0, e});
    end
    for (int p = 0; p < 16; p++) begin
      rowDrv = p[3:0]; #1;
      check("R1 outputs zero after reset", {16'h0, gOutOdd, gOutEven}, 32'h0);
    end

    // R2 and R3: select sweep with line coverage
    for (int j = 0; j < 16; j++) hitCount[j] = 0;
    for (int s = 0; s < 4; s++) begin
      logic [1:0] s2;
      s2 = s[1:0];
      cfgWrite(2'd0, {8'h0, s2, s2, s2, s2});
      for (int j = 0; j < 16; j++) begin
        logic [3:0] e;
        driveLine(j);
        for (int i = 0; i < 4; i++) e[i] = (j == s*4 + i);
        check("R2 input select", {28'h0, rowIn}, {28'h0, e});
        if (rowIn != 4'h0) hitCount[j]++;
      end
    end
    for (int j = 0; j < 16; j++) check("R3 line reached once", hitCount[j], 1);

    // R8: per-net select fields, net i uses select i -> line 5i
    cfgWrite(2'd0, 16'h00E4);
    for (int j = 0; j < 16; j++) begin
      logic [3:0] e;
      driveLine(j);
      for (int i = 0; i < 4; i++) e[i] = (j == 5*i);
      check("R8 select field layout", {28'h0, rowIn}, {28'h0, e});
    end

    // R4 and R6: all codes against all raw-net patterns, all enables on
    cfgWrite(2'd2, 16'hFFFF);
    for (int c = 0; c < 16; c++) begin
      logic [15:0] codes;
      codes = {4{c[3:0]}};
      cfgWrite(2'd1, codes);
      for (int p = 0; p < 16; p++) begin
        rowDrv = p[3:0]; #1;
        check("R4 table function", {16'h0, gOutOdd, gOutEven},
              {16'h0, gOutExp(codes, 16'hFFFF, p[3:0])});
      end
    end

    // R5: named codes on table 0, observed on even line 0
    begin
      logic [3:0] named [9];
      named = '{4'h0, 4'hF, 4'h3, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hE};
      for (int n = 0; n < 9; n++) begin
        cfgWrite(2'd1, {12'h0, named[n]});
        for (int ab = 0; ab < 4; ab++) begin
          logic a, b, e;
          a = ab[1]; b = ab[0];
          rowDrv = {2'b00, b, a}; #1;
          case (named[n])
            4'h0: e = 1'b0;
            4'hF: e = 1'b1;
            4'h3: e = a;
            4'h5: e = b;
            4'h6: e = a ^ b;
            4'h7: e = a | b;
            4'h8: e = ~(a | b);
            4'h9: e = ~(a ^ b);
            default: e = ~(a & b);
          endcase
          check("R5 named code", {31'h0, gOutEven[0]}, {31'h0, e});
        end
      end
    end

    // R6: one-hot enables with distinct codes per table
    cfgWrite(2'd1, 16'h53F0);
    rowDrv = 4'b0101;
    for (int j = 0; j <= 16; j++) begin
      logic [15:0] en;
      en = (j < 16) ? (16'h1 << j) : 16'h0;
      cfgWrite(2'd2, en);
      #1;
      check("R6 enable fan-out", {16'h0, gOutOdd, gOutEven},
            {16'h0, gOutExp(16'h53F0, en, 4'b0101)});
    end

    // R7: write visible only after the accepting edge
    cfgWrite(2'd1, 16'hFFFF);
    cfgWrite(2'd2, 16'h0000);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 2'd2; cfgWrData = 16'hFFFF;
    #1;
    check("R7 no effect before edge", {16'h0, gOutOdd, gOutEven}, 32'h0);
    @(posedge clk);
    #1 cfgWrEn = 1'b0;
    #1;
    check("R7 effect after edge", {16'h0, gOutOdd, gOutEven}, 32'h0000FFFF);

    // R9: spare address
    cfgWrite(2'd1, 16'h3333);
    cfgWrite(2'd0, 16'h0000);
    rowDrv = 4'b1010;
    driveLine(2);
    cfgWrite(2'd3, 16'h0000);
    cfgWrite(2'd3, 16'hFFFF);
    #1;
    check("R9 spare write outputs", {16'h0, gOutOdd, gOutEven},
          {16'h0, gOutExp(16'h3333, 16'hFFFF, 4'b1010)});
    check("R9 spare write rowIn", {28'h0, rowIn}, 32'h4);

    // R10: quiet period
    repeat (5) @(posedge clk);
    #1;
    check("R10 outputs steady", {12'h0, rowIn, gOutOdd, gOutEven},
          {12'h0, 4'h4, gOutExp(16'h3333, 16'hFFFF, 4'b1010)});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule